// File: doc/BRIEF.md
# Dual Auto-Reload Timer

This block holds two identical up-counting timers for a small microcontroller core. Each timer is a pair of byte registers (low and high), a run bit, an overflow flag and a two-bit mode field. In the wide mode, the two bytes form one 16-bit counter. When it rolls over, software has to reload both bytes itself. In the reload mode, only the low byte counts. When it rolls over, it takes its new value from the high byte with no help from software, so the timer gives a fixed period.

Counting advances only on cycles where the shared tick enable is high and that timer's run bit is set. The overflow flag of each timer drives an interrupt request line. When the interrupt controller vectors to that timer's handler, it pulses the matching acknowledge line, and the acknowledge clears the flag. Software reads and writes the count bytes, the mode register and the control bits through a simple byte bus. Bus writes take effect on the next clock edge. Reads are combinational from the current address.

Top module: `dual_timer`

## Requirements
- R1: After reset, every readable address returns 0x00 and both interrupt request lines are low.
- R2: A timer's count bytes hold their value on a cycle where its run bit is clear or where the tick enable is low.
- R3: In wide mode (mode field not equal to 2), each enabled tick adds one to the 16-bit value {high, low}, and the carry out of the low byte goes into the high byte.
- R4: In wide mode, a tick that takes the value from 0xFFFF to 0x0000 sets that timer's overflow flag, and both bytes read 0x00 afterwards.
- R5: In reload mode (mode field equal to 2), only the low byte counts. A tick that finds the low byte at 0xFF loads it with the high byte and sets the overflow flag. The high byte does not change.
- R6: Address 0 is the control byte: bit 7 is the timer 1 flag, bit 6 is the timer 1 run bit, bit 5 is the timer 0 flag, and bit 4 is the timer 0 run bit. Bits 3..0 read as 0. A write loads bits 7..4.
- R7: Address 1 is the mode byte and keeps all eight bits as written. Timer 0 uses bits 1..0 and timer 1 uses bits 5..4, so 0x12 makes timer 1 wide and timer 0 reload.
- R8: A pulse on intAck[i] clears flag i on the next edge and leaves the other flag alone. If the same cycle also has an overflow of timer i, the flag stays set.
- R9: A control write that sets a flag bit raises that timer's interrupt request on the next cycle, with no overflow needed. ovfIrq[i] always equals flag i.
- R10: If a bus write to a count byte falls in the same cycle as a tick of that timer, the written value is stored in that byte.
- R11: Addresses 2, 3, 4 and 5 hold timer 0 low, timer 0 high, timer 1 low and timer 1 high. Addresses 6 and 7 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count enable shared by both timers |
| busWrEn | input | 1 | Write strobe for the byte bus |
| busAddr | input | 3 | Register address for both read and write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| intAck | input | 2 | Per-timer interrupt acknowledge pulse |
| ovfIrq | output | 2 | Per-timer overflow interrupt request |

## Verification
There are two pairs of events that can land on the same clock edge: a counting tick together with a bus write to the same timer's bytes or control bits, and an overflow together with the acknowledge from the interrupt controller. Directed steps force each pair on purpose. One step writes a low byte while that timer ticks. Another step pulses the acknowledge exactly when the low byte wraps. Each result is compared against a fixed literal value. After that, a long random run mixes ticks, writes and acknowledges at random, and after every edge a bench-side model predicts the read data and the request lines.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int NumTimers = 2;
  localparam int ByteW     = 8;
  localparam int AddrW     = 3;
  localparam int ModeW     = 2;
  localparam int NibbleW   = 4;
  localparam logic [ModeW-1:0] ModeReload = 2'd2;
  localparam logic [AddrW-1:0] AddrCtrl   = 3'd0;
  localparam logic [AddrW-1:0] AddrMode   = 3'd1;
  localparam logic [AddrW-1:0] AddrCount  = 3'd2;

  typedef struct packed {
    logic                 wrCtrl;
    logic                 wrMode;
    logic [NumTimers-1:0] wrLo;
    logic [NumTimers-1:0] wrHi;
    logic [NumTimers-1:0] countEn;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import dual_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 busWrEn,
  input  logic [AddrW-1:0]     busAddr,
  input  logic [ByteW-1:0]     busWrData,
  input  logic [NumTimers-1:0] intAck,
  input  logic [NumTimers-1:0] wrap,
  output tmrStrobe_t           strobe,
  output logic [NumTimers-1:0] runBits,
  output logic [NumTimers-1:0] ovfFlags
);
  always_comb begin
    strobe.wrCtrl = busWrEn && (busAddr == AddrCtrl);
    strobe.wrMode = busWrEn && (busAddr == AddrMode);
  end

  for (genvar t = 0; t < NumTimers; t++) begin : g_ctl
    localparam logic [AddrW-1:0] LoAddr = AddrCount + AddrW'(2 * t);
    localparam logic [AddrW-1:0] HiAddr = LoAddr + AddrW'(1);
    localparam int RunBit = NibbleW + 2 * t;
    localparam int OvfBit = RunBit + 1;

    always_comb begin
      strobe.wrLo[t]    = busWrEn && (busAddr == LoAddr);
      strobe.wrHi[t]    = busWrEn && (busAddr == HiAddr);
      strobe.countEn[t] = tickEn && runBits[t];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runBits[t]  <= 1'b0;
        ovfFlags[t] <= 1'b0;
      end else if (strobe.wrCtrl) begin
        runBits[t]  <= busWrData[RunBit];
        ovfFlags[t] <= busWrData[OvfBit];
      end else if (wrap[t]) begin
        ovfFlags[t] <= 1'b1;
      end else if (intAck[t]) begin
        ovfFlags[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import dual_timer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrStrobe_t                      strobe,
  input  logic [ByteW-1:0]                busWrData,
  output logic [NumTimers-1:0][ByteW-1:0] loByte,
  output logic [NumTimers-1:0][ByteW-1:0] hiByte,
  output logic [ByteW-1:0]                modeReg,
  output logic [NumTimers-1:0]            wrap
);
  localparam logic [ByteW-1:0]   ByteMax = '1;
  localparam logic [2*ByteW-1:0] WordMax = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= '0;
    else if (strobe.wrMode) modeReg <= busWrData;
  end

  for (genvar t = 0; t < NumTimers; t++) begin : g_tmr
    logic                 autoRl;
    logic [ByteW-1:0]     nextLo;
    logic [ByteW-1:0]     nextHi;
    logic [2*ByteW-1:0]   wideSum;

    always_comb begin
      autoRl  = (modeReg[NibbleW*t +: ModeW] == ModeReload);
      wideSum = {hiByte[t], loByte[t]} + (2*ByteW)'(1);
      nextLo  = loByte[t];
      nextHi  = hiByte[t];
      wrap[t] = 1'b0;
      if (strobe.countEn[t]) begin
        if (autoRl) begin
          wrap[t] = (loByte[t] == ByteMax);
          nextLo  = wrap[t] ? hiByte[t] : loByte[t] + ByteW'(1);
        end else begin
          wrap[t] = ({hiByte[t], loByte[t]} == WordMax);
          {nextHi, nextLo} = wideSum;
        end
      end
      if (strobe.wrLo[t]) nextLo = busWrData;
      if (strobe.wrHi[t]) nextHi = busWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loByte[t] <= '0;
        hiByte[t] <= '0;
      end else begin
        loByte[t] <= nextLo;
        hiByte[t] <= nextHi;
      end
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       busWrEn,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [1:0] intAck,
  output logic [1:0] ovfIrq
);
  tmrStrobe_t                      strobe;
  logic [NumTimers-1:0]            wrap;
  logic [NumTimers-1:0]            runBits;
  logic [NumTimers-1:0]            ovfFlags;
  logic [NumTimers-1:0][ByteW-1:0] loByte;
  logic [NumTimers-1:0][ByteW-1:0] hiByte;
  logic [ByteW-1:0]                modeReg;

  timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .intAck(intAck),
    .wrap(wrap), .strobe(strobe), .runBits(runBits), .ovfFlags(ovfFlags)
  );

  timer_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .loByte(loByte), .hiByte(hiByte), .modeReg(modeReg), .wrap(wrap)
  );

  assign ovfIrq = ovfFlags;

  always_comb begin
    case (busAddr)
      3'd0:    busRdData = {ovfFlags[1], runBits[1], ovfFlags[0], runBits[0], 4'b0000};
      3'd1:    busRdData = modeReg;
      3'd2:    busRdData = loByte[0];
      3'd3:    busRdData = hiByte[0];
      3'd4:    busRdData = loByte[1];
      3'd5:    busRdData = hiByte[1];
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_checks.sv
module dual_timer_checks (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             busWrEn,
  input logic [2:0]       busAddr,
  input logic [7:0]       busWrData,
  input logic [7:0]       busRdData,
  input logic [1:0]       intAck,
  input logic [1:0]       ovfIrq,
  input logic [1:0][7:0]  loByte,
  input logic [1:0][7:0]  hiByte
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busWrEn) |=> ($stable(loByte) && $stable(hiByte)));

  assert_ack_clear_t0_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck[0] && !busWrEn && !tickEn) |=> !ovfIrq[0]);

  assert_ack_clear_t1_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck[1] && !busWrEn && !tickEn) |=> !ovfIrq[1]);

  assert_sw_set_t0_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd0 && busWrData[5]) |=> ovfIrq[0]);

  assert_sw_set_t1_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd0 && busWrData[7]) |=> ovfIrq[1]);

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfIrq[0]) |-> ($past(tickEn) || $past(busWrEn)));

  always @(posedge clk) begin
    if (rstN && busAddr == 3'd0) begin
      assert_ctrl_low_R6: assert (busRdData[3:0] == 4'b0000)
        else $error("control low nibble not zero");
    end
  end
endmodule

bind dual_timer dual_timer_checks u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .intAck(intAck), .ovfIrq(ovfIrq), .loByte(loByte), .hiByte(hiByte)
);

// File: tb/dual_timer_bench.sv
`timescale 1ns/1ps
module dual_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [1:0] intAck = '0;
  logic [1:0] ovfIrq;

  int checks = 0;
  int fails = 0;

  logic [7:0] mLo [2];
  logic [7:0] mHi [2];
  logic [7:0] mMode;
  logic [1:0] mRun;
  logic [1:0] mOvf;

  always #4 clk = ~clk;

  dual_timer u_dual_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .intAck(intAck), .ovfIrq(ovfIrq)
  );

  function automatic logic [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return {mOvf[1], mRun[1], mOvf[0], mRun[0], 4'b0000};
      3'd1: return mMode;
      3'd2: return mLo[0];
      3'd3: return mHi[0];
      3'd4: return mLo[1];
      3'd5: return mHi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic checkVal(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelClock(logic te, logic we, logic [2:0] a, logic [7:0] d, logic [1:0] ack);
    logic [7:0] nLo [2];
    logic [7:0] nHi [2];
    logic [1:0] nRun, nOvf;
    for (int t = 0; t < 2; t++) begin
      logic w;
      logic [15:0] sum;
      w = 1'b0;
      nLo[t] = mLo[t];
      nHi[t] = mHi[t];
      if (te && mRun[t]) begin
        if (mMode[4*t +: 2] == 2'd2) begin
          w = (mLo[t] == 8'hFF);
          nLo[t] = w ? mHi[t] : mLo[t] + 8'd1;
        end else begin
          w = ({mHi[t], mLo[t]} == 16'hFFFF);
          sum = {mHi[t], mLo[t]} + 16'd1;
          nHi[t] = sum[15:8];
          nLo[t] = sum[7:0];
        end
      end
      if (we && a == 3'(2 + 2*t)) nLo[t] = d;
      if (we && a == 3'(3 + 2*t)) nHi[t] = d;
      if (we && a == 3'd0) begin
        nRun[t] = d[4 + 2*t];
        nOvf[t] = d[5 + 2*t];
      end else begin
        nRun[t] = mRun[t];
        nOvf[t] = w ? 1'b1 : (ack[t] ? 1'b0 : mOvf[t]);
      end
    end
    for (int t = 0; t < 2; t++) begin
      mLo[t] = nLo[t];
      mHi[t] = nHi[t];
    end
    mRun = nRun;
    mOvf = nOvf;
    if (we && a == 3'd1) mMode = d;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(string tag, logic te, logic we, logic [2:0] a, logic [7:0] d, logic [1:0] ack);
    tickEn = te; busWrEn = we; busAddr = a; busWrData = d; intAck = ack;
    #1;
    checkVal({tag, " read"}, busRdData, modelRead(a));
    checkVal({tag, " irq"}, {6'b0, ovfIrq}, {6'b0, mOvf});
    @(posedge clk);
    modelClock(te, we, a, d, ack);
    @(negedge clk);
  endtask

  task automatic peek(string tag, logic [2:0] a, logic [7:0] exp);
    tickEn = 1'b0; busWrEn = 1'b0; intAck = 2'b00; busAddr = a;
    #1;
    checkVal(tag, busRdData, exp);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++) begin
      mLo[t] = '0;
      mHi[t] = '0;
    end
    mMode = '0; mRun = '0; mOvf = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at every address
    for (int a = 0; a < 8; a++) peek("R1 reset", 3'(a), 8'h00);
    checkVal("R1 irq", {6'b0, ovfIrq}, 8'h00);

    // R7: mode byte keeps all bits
    step("R7", 0, 1, 3'd1, 8'h12, 2'b00);
    peek("R7 mode", 3'd1, 8'h12);

    // R11: load the count bytes through the map
    step("R11", 0, 1, 3'd2, 8'hFE, 2'b00);
    step("R11", 0, 1, 3'd3, 8'h80, 2'b00);
    step("R11", 0, 1, 3'd4, 8'hFE, 2'b00);
    step("R11", 0, 1, 3'd5, 8'hFF, 2'b00);
    peek("R11 t0 lo", 3'd2, 8'hFE);
    peek("R11 t1 hi", 3'd5, 8'hFF);

    // R6: start both timers
    step("R6", 0, 1, 3'd0, 8'h50, 2'b00);
    peek("R6 ctrl", 3'd0, 8'h50);

    // R5 / R4: two ticks reach both wraps
    step("R5", 1, 0, 3'd2, 8'h00, 2'b00);
    step("R4", 1, 0, 3'd4, 8'h00, 2'b00);
    peek("R5 reload lo", 3'd2, 8'h80);
    peek("R5 hi kept", 3'd3, 8'h80);
    peek("R4 lo zero", 3'd4, 8'h00);
    peek("R4 hi zero", 3'd5, 8'h00);
    checkVal("R4 irq", {6'b0, ovfIrq}, 8'h03);
    peek("R6 flags", 3'd0, 8'hF0);

    // R8: acknowledge timer 0 only
    step("R8", 0, 0, 3'd0, 8'h00, 2'b01);
    checkVal("R8 irq", {6'b0, ovfIrq}, 8'h02);

    // R3: one tick, then carry into the high byte
    step("R3", 1, 0, 3'd4, 8'h00, 2'b00);
    peek("R3 inc", 3'd4, 8'h01);
    step("R3", 0, 1, 3'd4, 8'hFF, 2'b00);
    step("R3", 1, 0, 3'd4, 8'h00, 2'b00);
    peek("R3 carry lo", 3'd4, 8'h00);
    peek("R3 carry hi", 3'd5, 8'h01);

    // R2: run bits cleared, then tick enable low
    step("R2", 0, 1, 3'd0, 8'h00, 2'b00);
    step("R2", 1, 0, 3'd2, 8'h00, 2'b00);
    step("R2", 1, 0, 3'd2, 8'h00, 2'b00);
    peek("R2 stopped", 3'd2, 8'h82);
    step("R2", 0, 1, 3'd0, 8'h10, 2'b00);
    step("R2", 0, 0, 3'd2, 8'h00, 2'b00);
    peek("R2 no tick", 3'd2, 8'h82);

    // R10: write and tick in the same cycle
    step("R10", 1, 1, 3'd2, 8'h33, 2'b00);
    peek("R10 write wins", 3'd2, 8'h33);

    // R9: software sets a flag
    step("R9", 0, 1, 3'd0, 8'h20, 2'b00);
    checkVal("R9 irq", {6'b0, ovfIrq}, 8'h01);

    // R8: wrap and acknowledge together keep the flag
    step("R8", 0, 1, 3'd2, 8'hFF, 2'b00);
    step("R8", 0, 1, 3'd0, 8'h10, 2'b00);
    step("R8", 1, 0, 3'd2, 8'h00, 2'b01);
    checkVal("R8 wrap+ack", {6'b0, ovfIrq}, 8'h01);

    // R11: unused addresses
    step("R11", 0, 1, 3'd6, 8'hFF, 2'b00);
    peek("R11 addr6", 3'd6, 8'h00);
    peek("R11 addr7", 3'd7, 8'h00);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [2:0] a;
      logic [7:0] d;
      we = ($urandom % 6) == 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (we && a == 3'd0 && ($urandom % 4) != 0) d = d | 8'h50;
      if (we && a == 3'd1) d = (($urandom % 2) == 0) ? 8'h12 : 8'h21;
      if (we && (a == 3'd3 || a == 3'd5) && ($urandom % 2) == 0) d = 8'hFF;
      step("RND", 1'($urandom % 2), we, a, d, 2'($urandom % 4));
    end

    report();
  end
endmodule